// File: doc/BRIEF.md
# TAP Instruction and Data Register Path

This block is the serial datapath that sits behind a boundary-scan test access port controller. A 4-bit instruction register chooses which data register lies between the serial input and the serial output. The choices are a 1-bit bypass register, a 32-bit identification register, or an external boundary-scan chain that returns its serial output to this block. The controller's state strobes (reset, capture, shift and update, for both the instruction path and the data path) arrive as level inputs that are valid for one test-clock cycle. The block answers with a serial output that is re-timed on the falling edge of the test clock, together with an output-enable for that pin.

The active instruction is decoded into one-hot mode flags. These are external test, sample/preload, identification and bypass, plus a clamp flag. The block also produces the controls for the external boundary chain: a select, gated capture, shift and update strobes, and a pin-drive flag. The pin-drive flag tells the boundary cells to put their update-stage values on the pins. Under clamp, the pins keep their preloaded boundary values while the short bypass register carries the serial traffic.

Top module: `tap_datapath`

## Requirements
- R1: After reset (rst_ni low) the active instruction is identification (opcode 0010), so idcode_o is 1. A cycle with tlr_i high also makes identification active, and tlr_i takes priority over update_ir_i when both are high in the same cycle.
- R2: A cycle with capture_ir_i high loads 0001 into the instruction shift stage. The following Shift-IR cycles present it on tdo_o least significant bit first, giving the sequence 1,0,0,0.
- R3: During Shift-IR, tdi_i enters the instruction shift stage at its MSB. The active instruction and every mode output change only on a cycle with update_ir_i (or tlr_i) high.
- R4: Decode of the active opcode: 0000 is external test (extest_o), 0001 is sample (sample_o), 0010 is identification (idcode_o), and 0100 is clamp (clamp_o and bypass_o). 1111 and every other value are bypass (bypass_o). Exactly one of extest_o, sample_o, idcode_o and bypass_o is high.
- R5: With the bypass register selected, capture_dr_i loads 0. During Shift-DR, tdo_o first gives that 0 and then each tdi_i bit one cycle after it entered.
- R6: With identification selected, capture_dr_i loads {version[3:0], part[15:0], manufacturer[10:0], 1}. Shift-DR emits this value least significant bit first, so bit 0 is always 1.
- R7: pin_drive_o is high under external test and under clamp, and low for every other instruction. Under clamp the bypass register is the serial path.
- R8: Under external test or sample, bsr_sel_o is high and tdo_o during Shift-DR follows bsr_tdo_i. bsr_capture_o, bsr_shift_o and bsr_update_o repeat the DR strobes only while bsr_sel_o is high.
- R9: tdo_o and tdo_en_o change on the falling edge of tck_i. tdo_en_o is 1 only when Shift-IR or Shift-DR was active at that edge. Outside the shift states, tdo_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tdi_i | input | 1 | Serial data in |
| tlr_i | input | 1 | Controller in Test-Logic-Reset |
| capture_ir_i | input | 1 | Capture-IR state |
| shift_ir_i | input | 1 | Shift-IR state |
| update_ir_i | input | 1 | Update-IR state |
| capture_dr_i | input | 1 | Capture-DR state |
| shift_dr_i | input | 1 | Shift-DR state |
| update_dr_i | input | 1 | Update-DR state |
| bsr_tdo_i | input | 1 | Serial return from the boundary chain |
| tdo_o | output | 1 | Serial data out, falling-edge timed |
| tdo_en_o | output | 1 | Output enable for the serial-out pin |
| extest_o | output | 1 | External test active |
| sample_o | output | 1 | Sample/preload active |
| idcode_o | output | 1 | Identification active |
| clamp_o | output | 1 | Clamp active |
| bypass_o | output | 1 | Bypass register is the data path |
| bsr_sel_o | output | 1 | Boundary chain is the data path |
| pin_drive_o | output | 1 | Boundary update values drive the pins |
| bsr_capture_o | output | 1 | Capture strobe to the boundary chain |
| bsr_shift_o | output | 1 | Shift strobe to the boundary chain |
| bsr_update_o | output | 1 | Update strobe to the boundary chain |

## Verification
Two functions can fall in the same cycle. The first pair is a reset request and an instruction update: the bench raises tlr_i and update_ir_i together after shifting in a bypass opcode, then checks that identification, not bypass, becomes active. The second pair is shifting into and out of the bypass register: on every Shift-DR cycle it emits its old bit and takes a new one. The bench judges this by comparing tdo_o with the tdi_i pattern delayed by exactly one cycle, behind a leading 0. All sixteen opcodes are swept, and the data path each one selects is shifted end to end.

// File: rtl/tap_dp_pkg.sv
package tap_dp_pkg;
  localparam int unsigned IR_W  = 4;
  localparam int unsigned ID_W  = 32;
  localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0001;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'b0010;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [1:0] {
    SEL_BSR = 2'd0,
    SEL_ID  = 2'd1,
    SEL_BYP = 2'd2
  } dr_sel_e;

  typedef struct packed {
    logic extest;
    logic sample;
    logic idcode;
    logic clamp;
    logic bypass;
  } mode_t;
endpackage

// File: rtl/tap_ir.sv
module tap_ir
  import tap_dp_pkg::*;
#(
  parameter int unsigned    W        = IR_W,
  parameter logic [W-1:0]   CAP_VAL  = IR_CAPTURE,
  parameter logic [W-1:0]   RESET_OP = OP_IDCODE
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         tlr_i,
  input  logic         capture_i,
  input  logic         shift_i,
  input  logic         update_i,
  input  logic         tdi_i,
  output logic         sr_lsb_o,
  output logic [W-1:0] ir_o
);
  logic [W-1:0] sr_q;
  logic [W-1:0] ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= '0;
    else if (capture_i) sr_q <= CAP_VAL;
    else if (shift_i)   sr_q <= {tdi_i, sr_q[W-1:1]};
  end

  // reset request beats a coincident update
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       ir_q <= RESET_OP;
    else if (tlr_i)    ir_q <= RESET_OP;
    else if (update_i) ir_q <= sr_q;
  end

  assign sr_lsb_o = sr_q[0];
  assign ir_o     = ir_q;
endmodule

// File: rtl/tap_decode.sv
module tap_decode
  import tap_dp_pkg::*;
#(
  parameter int unsigned  W        = IR_W,
  parameter logic [W-1:0] OP_CLAMP = 4'b0100
) (
  input  logic [W-1:0] ir_i,
  output mode_t        mode_o,
  output dr_sel_e      sel_o
);
  always_comb begin
    mode_o = '0;
    sel_o  = SEL_BYP;
    unique case (ir_i)
      OP_EXTEST: begin mode_o.extest = 1'b1; sel_o = SEL_BSR; end
      OP_SAMPLE: begin mode_o.sample = 1'b1; sel_o = SEL_BSR; end
      OP_IDCODE: begin mode_o.idcode = 1'b1; sel_o = SEL_ID;  end
      OP_CLAMP:  begin mode_o.clamp  = 1'b1; mode_o.bypass = 1'b1; end
      default:   mode_o.bypass = 1'b1;
    endcase
  end
endmodule

// File: rtl/tap_dr_reg.sv
module tap_dr_reg #(
  parameter int unsigned  W       = 1,
  parameter logic [W-1:0] CAP_VAL = '0
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic shift_i,
  input  logic tdi_i,
  output logic lsb_o
);
  logic [W-1:0] q;
  logic [W-1:0] q_shift;

  generate
    if (W == 1) begin : g_single
      assign q_shift = tdi_i;
    end else begin : g_multi
      assign q_shift = {tdi_i, q[W-1:1]};
    end
  endgenerate

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        q <= CAP_VAL;
    else if (capture_i) q <= CAP_VAL;
    else if (shift_i)   q <= q_shift;
  end

  assign lsb_o = q[0];
endmodule

// File: rtl/tap_datapath.sv
module tap_datapath
  import tap_dp_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h1,
  parameter logic [15:0] ID_PART    = 16'h5A3C,
  parameter logic [10:0] ID_MFR     = 11'h2B7,
  parameter logic [3:0]  OP_CLAMP   = 4'b0100
) (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic tdi_i,
  input  logic tlr_i,
  input  logic capture_ir_i,
  input  logic shift_ir_i,
  input  logic update_ir_i,
  input  logic capture_dr_i,
  input  logic shift_dr_i,
  input  logic update_dr_i,
  input  logic bsr_tdo_i,
  output logic tdo_o,
  output logic tdo_en_o,
  output logic extest_o,
  output logic sample_o,
  output logic idcode_o,
  output logic clamp_o,
  output logic bypass_o,
  output logic bsr_sel_o,
  output logic pin_drive_o,
  output logic bsr_capture_o,
  output logic bsr_shift_o,
  output logic bsr_update_o
);
  localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MFR, 1'b1};

  logic [IR_W-1:0] ir;
  logic            ir_lsb;
  mode_t           mode;
  dr_sel_e         sel;
  logic            id_lsb;
  logic            byp_lsb;
  logic            tdo_d;
  logic            tdo_q;
  logic            en_q;

  tap_ir #(
    .W       (IR_W),
    .CAP_VAL (IR_CAPTURE),
    .RESET_OP(OP_IDCODE)
  ) u_ir (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .tlr_i    (tlr_i),
    .capture_i(capture_ir_i),
    .shift_i  (shift_ir_i),
    .update_i (update_ir_i),
    .tdi_i    (tdi_i),
    .sr_lsb_o (ir_lsb),
    .ir_o     (ir)
  );

  tap_decode #(
    .W       (IR_W),
    .OP_CLAMP(OP_CLAMP)
  ) u_dec (
    .ir_i  (ir),
    .mode_o(mode),
    .sel_o (sel)
  );

  tap_dr_reg #(
    .W      (ID_W),
    .CAP_VAL(ID_VALUE)
  ) u_id (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .capture_i(capture_dr_i && sel == SEL_ID),
    .shift_i  (shift_dr_i && sel == SEL_ID),
    .tdi_i    (tdi_i),
    .lsb_o    (id_lsb)
  );

  tap_dr_reg #(
    .W      (1),
    .CAP_VAL(1'b0)
  ) u_byp (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .capture_i(capture_dr_i && sel == SEL_BYP),
    .shift_i  (shift_dr_i && sel == SEL_BYP),
    .tdi_i    (tdi_i),
    .lsb_o    (byp_lsb)
  );

  always_comb begin
    tdo_d = 1'b0;
    if (shift_ir_i) begin
      tdo_d = ir_lsb;
    end else if (shift_dr_i) begin
      unique case (sel)
        SEL_BSR: tdo_d = bsr_tdo_i;
        SEL_ID:  tdo_d = id_lsb;
        default: tdo_d = byp_lsb;
      endcase
    end
  end

  // falling-edge retime gives the next stage half a cycle of setup
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      tdo_q <= tdo_d;
      en_q  <= shift_ir_i || shift_dr_i;
    end
  end

  assign tdo_o         = tdo_q;
  assign tdo_en_o      = en_q;
  assign extest_o      = mode.extest;
  assign sample_o      = mode.sample;
  assign idcode_o      = mode.idcode;
  assign clamp_o       = mode.clamp;
  assign bypass_o      = mode.bypass;
  assign bsr_sel_o     = (sel == SEL_BSR);
  assign pin_drive_o   = mode.extest || mode.clamp;
  assign bsr_capture_o = capture_dr_i && bsr_sel_o;
  assign bsr_shift_o   = shift_dr_i && bsr_sel_o;
  assign bsr_update_o  = update_dr_i && bsr_sel_o;
endmodule

// File: rtl/tap_datapath_chk.sv
module tap_datapath_chk (
  input logic tck_i,
  input logic rst_ni,
  input logic tdi_i,
  input logic tlr_i,
  input logic capture_ir_i,
  input logic shift_ir_i,
  input logic update_ir_i,
  input logic capture_dr_i,
  input logic shift_dr_i,
  input logic update_dr_i,
  input logic bsr_tdo_i,
  input logic tdo_o,
  input logic tdo_en_o,
  input logic extest_o,
  input logic sample_o,
  input logic idcode_o,
  input logic clamp_o,
  input logic bypass_o,
  input logic bsr_sel_o,
  input logic pin_drive_o,
  input logic bsr_capture_o,
  input logic bsr_shift_o,
  input logic bsr_update_o
);
  p_tlr_idcode_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tlr_i |=> idcode_o);

  p_mode_hold_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!tlr_i && !update_ir_i) |=>
      $stable({extest_o, sample_o, idcode_o, clamp_o, bypass_o}));

  p_one_mode_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $countones({extest_o, sample_o, idcode_o, bypass_o}) == 1);

  p_clamp_path_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    clamp_o |-> (pin_drive_o && bypass_o && !bsr_sel_o));

  p_bsr_gate_r8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (bsr_shift_o || bsr_capture_o || bsr_update_o) |-> (extest_o || sample_o));

  p_tdo_en_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o == (shift_ir_i || shift_dr_i));

  p_tdo_idle_r9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !tdo_en_o |-> !tdo_o);
endmodule

bind tap_datapath tap_datapath_chk u_chk (.*);

// File: tb/tap_datapath_bench.sv
`timescale 1ns/1ps
module tap_datapath_bench;
  localparam logic [3:0]  VER  = 4'h1;
  localparam logic [15:0] PART = 16'h5A3C;
  localparam logic [10:0] MFR  = 11'h2B7;
  localparam logic [31:0] ID   = {VER, PART, MFR, 1'b1};

  logic tck_i = 1'b0, rst_ni = 1'b0, tdi_i = 1'b0, tlr_i = 1'b0;
  logic capture_ir_i = 1'b0, shift_ir_i = 1'b0, update_ir_i = 1'b0;
  logic capture_dr_i = 1'b0, shift_dr_i = 1'b0, update_dr_i = 1'b0;
  logic bsr_tdo_i = 1'b0;
  logic tdo_o, tdo_en_o, extest_o, sample_o, idcode_o, clamp_o, bypass_o;
  logic bsr_sel_o, pin_drive_o, bsr_capture_o, bsr_shift_o, bsr_update_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 tck_i = ~tck_i;

  tap_datapath #(.ID_VERSION(VER), .ID_PART(PART), .ID_MFR(MFR), .OP_CLAMP(4'b0100))
  u_tap_datapath (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck_i);
    #1;
  endtask

  task automatic idle();
    {tlr_i, capture_ir_i, shift_ir_i, update_ir_i} = '0;
    {capture_dr_i, shift_dr_i, update_dr_i} = '0;
  endtask

  function automatic logic [4:0] exp_mode(input logic [3:0] op);
    // {extest, sample, idcode, clamp, bypass}
    case (op)
      4'b0000: return 5'b10000;
      4'b0001: return 5'b01000;
      4'b0010: return 5'b00100;
      4'b0100: return 5'b00011;
      default: return 5'b00001;
    endcase
  endfunction

  function automatic logic [4:0] act_mode();
    return {extest_o, sample_o, idcode_o, clamp_o, bypass_o};
  endfunction

  // shifts op into IR, returns captured bits as seen on tdo
  task automatic load_ir(input logic [3:0] op, input logic [4:0] prev, input bit do_update);
    logic [3:0] seen;
    idle(); capture_ir_i = 1'b1; tick();
    idle(); shift_ir_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tdi_i = op[i];
      tick();
      seen[i] = tdo_o;
      check(tdo_en_o == 1'b1, "R9 en in shift-ir", {31'd0, tdo_en_o}, 32'd1);
    end
    check(seen == 4'b0001, "R2 capture pattern", {28'd0, seen}, 32'd1);
    idle(); tick();
    check(act_mode() == prev, "R3 mode held before update", {27'd0, act_mode()}, {27'd0, prev});
    check(tdo_en_o == 1'b0 && tdo_o == 1'b0, "R9 idle tdo", {30'd0, tdo_en_o, tdo_o}, 32'd0);
    if (do_update) begin
      update_ir_i = 1'b1; tick(); idle();
    end
  endtask

  task automatic run_dr(input logic [3:0] op);
    logic [4:0]  m;
    logic [31:0] pat, got, exp;
    m   = exp_mode(op);
    pat = 32'hC3A5_1E96 ^ {8{op}};
    got = '0;
    idle(); capture_dr_i = 1'b1; tick();
    idle(); shift_dr_i = 1'b1;
    for (int i = 0; i < 32; i++) begin
      tdi_i     = pat[i];
      bsr_tdo_i = ~pat[(i + 5) % 32];
      #1;
      if (m[4] || m[3])
        check(bsr_shift_o == 1'b1, "R8 bsr shift strobe", {31'd0, bsr_shift_o}, 32'd1);
      else
        check(bsr_shift_o == 1'b0, "R8 bsr shift gated", {31'd0, bsr_shift_o}, 32'd0);
      tick();
      got[i] = tdo_o;
    end
    idle(); tick();
    if (m[4] || m[3]) begin
      for (int i = 0; i < 32; i++) exp[i] = ~pat[(i + 5) % 32];
      check(got == exp, "R8 bsr serial return", got, exp);
    end else if (m[2]) begin
      check(got == ID, "R6 idcode shift", got, ID);
      check(got[0] == 1'b1, "R6 idcode lsb", {31'd0, got[0]}, 32'd1);
    end else begin
      exp = {pat[30:0], 1'b0};
      check(got == exp, "R5 bypass delay", got, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [4:0] prev;
    #23;
    check(act_mode() == 5'b00100, "R1 reset idcode", {27'd0, act_mode()}, 32'h4);
    check(tdo_en_o == 1'b0 && tdo_o == 1'b0, "R9 reset tdo", {30'd0, tdo_en_o, tdo_o}, 32'd0);
    rst_ni = 1'b1;
    tick(); tick();
    run_dr(4'b0010);
    prev = 5'b00100;

    for (int op = 0; op < 16; op++) begin
      load_ir(op[3:0], prev, 1'b1);
      prev = exp_mode(op[3:0]);
      check(act_mode() == prev, "R4 decode", {27'd0, act_mode()}, {27'd0, prev});
      check(pin_drive_o == (prev[4] | prev[1]), "R7 pin drive",
            {31'd0, pin_drive_o}, {31'd0, prev[4] | prev[1]});
      check(bsr_sel_o == (prev[4] | prev[3]), "R8 bsr select",
            {31'd0, bsr_sel_o}, {31'd0, prev[4] | prev[3]});
      run_dr(op[3:0]);
      update_dr_i = 1'b1; #1;
      check(bsr_update_o == (prev[4] | prev[3]), "R8 bsr update strobe",
            {31'd0, bsr_update_o}, {31'd0, prev[4] | prev[3]});
      tick(); idle();
    end

    // reset request and update in the same cycle
    load_ir(4'b1111, prev, 1'b0);
    tlr_i = 1'b1; update_ir_i = 1'b1; tick(); idle();
    check(act_mode() == 5'b00100, "R1 tlr beats update", {27'd0, act_mode()}, 32'h4);

    // tlr alone from clamp
    load_ir(4'b0100, 5'b00100, 1'b1);
    check(clamp_o && bypass_o && pin_drive_o, "R7 clamp path",
          {29'd0, clamp_o, bypass_o, pin_drive_o}, 32'd7);
    tlr_i = 1'b1; tick(); idle();
    check(act_mode() == 5'b00100, "R1 tlr restores idcode", {27'd0, act_mode()}, 32'h4);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule